// File: doc/BRIEF.md
# SDRAM Bank Command Legality Monitor

This block sits passively on the command bus of a four-bank SDRAM and watches what the controller sends. Every clock it decodes chip select, the three strobes, the bank address and the auto-precharge flag. From that it keeps a shadow state for each bank: idle, opening a row, row open, reading, writing, write recovery, a burst or recovery that ends in auto precharge, or precharging. It also keeps a shadow of the device-wide busy windows that follow a refresh or a mode register load.

Each command is classed as legal, illegal for the bank it addresses, illegal for the whole device, or a timing violation. An offending command produces a one-cycle error pulse with a numeric reason and the bank involved. The monitor treats a rejected command as if it had never been issued, so a single mistake does not corrupt the tracking that follows. All timing limits are parameters counted in clock cycles.

Top module: `sdcc_checker`

## Requirements
- R1: While reset is asserted and after it, with no offending command, err_pulse is 0 and err_code and err_bank read 0. Commands decode with cs_n low from {ras_n,cas_n,we_n}: 000 mode load, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst stop, 111 no-op. cs_n high is deselect.
- R2: A command is sampled on a rising edge. If it is offending, err_pulse is high for exactly the following clock cycle, with err_code and err_bank. err_bank is the addressed bank, except for precharge-all (precharge with ap=1), which reports the lowest-numbered offending bank.
- R3: A read or write to a bank that is idle or precharging gives code 3.
- R4: An activate to a bank that is opening a row, has a row open, or is in a plain burst or recovery gives code 4. An activate to a bank that is precharging (fewer than TRP cycles since the precharge started) gives code 10.
- R5: A precharge, activate, read or write to a bank whose burst or write recovery ends in auto precharge gives code 5.
- R6: For TRC cycles after an accepted refresh, and TMRD cycles after an accepted mode load, any command other than no-op or deselect gives code 1.
- R7: A refresh or mode load while any bank is not idle gives code 2.
- R8: A read or write fewer than TRCD cycles after the activate of that bank gives code 6.
- R9: A precharge of a bank with an open row fewer than TRAS cycles after its activate gives code 7.
- R10: An activate fewer than TRRD cycles after the previous accepted activate gives code 8.
- R11: A precharge during the TDPL cycles of write recovery after a plain write burst gives code 9.
- R12: A read or write to a bank in a plain burst is legal and restarts the burst. A burst occupies BURST_LEN cycles, and a write burst is followed by TDPL recovery cycles. An auto-precharge burst then precharges for TRP cycles and leaves the bank idle.
- R13: A command that is reported as offending changes no tracked state.
- R14: Device errors (codes 1 and 2) take precedence over bank errors. Bank errors take precedence over code 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising-edge sampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank address |
| ap | input | 1 | Auto precharge on read/write; all banks on precharge |
| err_pulse | output | 1 | One-cycle flag for an offending command |
| err_code | output | 4 | Reason code, 0 when no error |
| err_bank | output | 2 | Bank involved, 0 when no error |

## Verification
The assertions assume one command per clock, sampled at the rising edge. They also assume parameter values that keep TRAS at least TRCD and TRC at least two, so that an accepted read always finds a mature row and a refresh always opens a busy window. The stimulus changes the pins only on falling edges and issues exactly one command per cycle with the default parameters. Command spacing is counted against those parameters so that each boundary case lands on the first illegal cycle or the first legal cycle.

// File: rtl/sdcc_pkg.sv
package sdcc_pkg;

    typedef enum logic [3:0] {
        C_MRS, C_REF, C_PRE, C_ACT, C_WR, C_RD, C_BST, C_NOP, C_DESEL
    } cmd_e;

    typedef enum logic [3:0] {
        B_IDLE, B_ACTIVATING, B_ACTIVE, B_READ, B_WRITE, B_WR_RECOV,
        B_READ_AP, B_WRITE_AP, B_WR_RECOV_AP, B_PRECHARGING
    } bank_st_e;

    typedef enum logic [3:0] {
        E_NONE      = 4'd0,
        E_DEV_BUSY  = 4'd1,
        E_DEV_OPEN  = 4'd2,
        E_NO_ROW    = 4'd3,
        E_ROW_OPEN  = 4'd4,
        E_AP_BUSY   = 4'd5,
        E_TRCD      = 4'd6,
        E_TRAS      = 4'd7,
        E_TRRD      = 4'd8,
        E_WR_RECOV  = 4'd9,
        E_TRP       = 4'd10
    } err_e;

endpackage

// File: rtl/sdcc_decode.sv
module sdcc_decode
    import sdcc_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        if (cs_n) begin
            cmd = C_DESEL;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b000:  cmd = C_MRS;
                3'b001:  cmd = C_REF;
                3'b010:  cmd = C_PRE;
                3'b011:  cmd = C_ACT;
                3'b100:  cmd = C_WR;
                3'b101:  cmd = C_RD;
                3'b110:  cmd = C_BST;
                default: cmd = C_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdcc_bank.sv
module sdcc_bank
    import sdcc_pkg::*;
#(
    parameter int TRCD      = 3,
    parameter int TRAS      = 6,
    parameter int TRP       = 3,
    parameter int TDPL      = 2,
    parameter int BURST_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  cmd_e cmd,
    input  logic sel,
    input  logic ap,
    input  logic accept,
    output err_e err,
    output logic idle
);

    localparam int TMAX = (BURST_LEN > TRP) ? ((BURST_LEN > TDPL) ? BURST_LEN : TDPL)
                                            : ((TRP > TDPL) ? TRP : TDPL);
    localparam int TW   = $clog2(TMAX + 1);
    localparam int RW   = $clog2(TRAS + 1);

    typedef struct packed {
        bank_st_e       st;
        logic [TW-1:0]  tmr;
        logic [RW-1:0]  ras;
    } bank_reg_t;

    bank_reg_t      r_q, r_d;
    bank_st_e       cur_st;
    logic [TW-1:0]  cur_tmr;
    logic           adv;
    logic           ap_busy;
    logic           row_open;
    logic           ras_ok;

    // Effective state at this edge: a timed state whose count has run out
    // is already its successor.
    always_comb begin
        cur_st  = r_q.st;
        cur_tmr = r_q.tmr;
        adv     = 1'b0;
        case (r_q.st)
            B_ACTIVATING: if (r_q.ras >= RW'(TRCD)) begin
                cur_st = B_ACTIVE;      adv = 1'b1;
            end
            B_READ: if (r_q.tmr == '0) begin
                cur_st = B_ACTIVE;      adv = 1'b1;
            end
            B_WRITE: if (r_q.tmr == '0) begin
                cur_st = B_WR_RECOV;    cur_tmr = TW'(TDPL - 1); adv = 1'b1;
            end
            B_WR_RECOV: if (r_q.tmr == '0) begin
                cur_st = B_ACTIVE;      adv = 1'b1;
            end
            B_READ_AP: if (r_q.tmr == '0) begin
                cur_st = B_PRECHARGING; cur_tmr = TW'(TRP - 1); adv = 1'b1;
            end
            B_WRITE_AP: if (r_q.tmr == '0) begin
                cur_st = B_WR_RECOV_AP; cur_tmr = TW'(TDPL - 1); adv = 1'b1;
            end
            B_WR_RECOV_AP: if (r_q.tmr == '0) begin
                cur_st = B_PRECHARGING; cur_tmr = TW'(TRP - 1); adv = 1'b1;
            end
            B_PRECHARGING: if (r_q.tmr == '0) begin
                cur_st = B_IDLE;        adv = 1'b1;
            end
            default: ;
        endcase
    end

    assign ap_busy  = (cur_st == B_READ_AP) || (cur_st == B_WRITE_AP) || (cur_st == B_WR_RECOV_AP);
    assign row_open = (cur_st == B_ACTIVATING) || (cur_st == B_ACTIVE) ||
                      (cur_st == B_READ) || (cur_st == B_WRITE);
    assign ras_ok   = (r_q.ras >= RW'(TRAS));
    assign idle     = (cur_st == B_IDLE);

    // Legality of the command for this bank
    always_comb begin
        err = E_NONE;
        if (sel) begin
            case (cmd)
                C_ACT: begin
                    if (ap_busy)                         err = E_AP_BUSY;
                    else if (cur_st == B_PRECHARGING)    err = E_TRP;
                    else if (cur_st != B_IDLE)           err = E_ROW_OPEN;
                end
                C_RD, C_WR: begin
                    if (ap_busy)                         err = E_AP_BUSY;
                    else if (cur_st == B_IDLE || cur_st == B_PRECHARGING)
                                                         err = E_NO_ROW;
                    else if (cur_st == B_ACTIVATING)     err = E_TRCD;
                end
                C_PRE: begin
                    if (ap_busy)                         err = E_AP_BUSY;
                    else if (cur_st == B_WR_RECOV)       err = E_WR_RECOV;
                    else if (row_open && !ras_ok)        err = E_TRAS;
                end
                default: ;
            endcase
        end
    end

    // Next state
    always_comb begin
        r_d.st  = cur_st;
        r_d.tmr = adv ? cur_tmr : ((r_q.tmr != '0) ? r_q.tmr - 1'b1 : '0);
        r_d.ras = ras_ok ? r_q.ras : r_q.ras + 1'b1;
        if (accept && sel) begin
            case (cmd)
                C_ACT: begin
                    r_d.st  = B_ACTIVATING;
                    r_d.ras = RW'(1);
                end
                C_RD: begin
                    r_d.st  = ap ? B_READ_AP : B_READ;
                    r_d.tmr = TW'(BURST_LEN - 1);
                end
                C_WR: begin
                    r_d.st  = ap ? B_WRITE_AP : B_WRITE;
                    r_d.tmr = TW'(BURST_LEN - 1);
                end
                C_PRE: if (row_open) begin
                    r_d.st  = B_PRECHARGING;
                    r_d.tmr = TW'(TRP - 1);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= B_IDLE;
            r_q.tmr <= '0;
            r_q.ras <= RW'(TRAS);
        end else begin
            r_q <= r_d;
        end
    end

    // R8: an accepted column command only reaches a row that has matured
    a_r8_col_after_trcd: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && sel && (cmd == C_RD || cmd == C_WR)) |-> (r_q.ras >= RW'(TRCD)));

    // R9: an accepted precharge of an open row respects the row-active minimum
    a_r9_pre_after_tras: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && sel && cmd == C_PRE && cur_st != B_IDLE && cur_st != B_PRECHARGING)
            |-> (r_q.ras >= RW'(TRAS)));

    // R13: an idle bank stays idle unless an accepted activate targets it
    a_r13_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == B_IDLE && !(accept && sel && cmd == C_ACT)) |=> (r_q.st == B_IDLE));

endmodule

// File: rtl/sdcc_device.sv
module sdcc_device
    import sdcc_pkg::*;
#(
    parameter int TRC  = 8,
    parameter int TMRD = 2,
    parameter int TRRD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  cmd_e cmd,
    input  logic accept,
    output logic busy,
    output logic rrd_short
);

    localparam int DMAX = (TRC > TMRD) ? TRC : TMRD;
    localparam int DW   = $clog2(DMAX + 1);
    localparam int RRW  = $clog2(TRRD + 1);

    typedef struct packed {
        logic           busy;
        logic [DW-1:0]  tmr;
        logic [RRW-1:0] rrd;
    } dev_reg_t;

    dev_reg_t r_q, r_d;

    assign busy      = r_q.busy && (r_q.tmr != '0);
    assign rrd_short = (r_q.rrd < RRW'(TRRD));

    always_comb begin
        r_d.busy = busy;
        r_d.tmr  = busy ? r_q.tmr - 1'b1 : '0;
        r_d.rrd  = rrd_short ? r_q.rrd + 1'b1 : r_q.rrd;
        if (accept) begin
            case (cmd)
                C_REF: begin
                    r_d.busy = 1'b1;
                    r_d.tmr  = DW'(TRC - 1);
                end
                C_MRS: begin
                    r_d.busy = 1'b1;
                    r_d.tmr  = DW'(TMRD - 1);
                end
                C_ACT:   r_d.rrd = RRW'(1);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.busy <= 1'b0;
            r_q.tmr  <= '0;
            r_q.rrd  <= RRW'(TRRD);
        end else begin
            r_q <= r_d;
        end
    end

    // R6: an accepted refresh opens a busy window on the next cycle
    a_r6_refresh_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd == C_REF) |=> (busy || TRC < 2));

endmodule

// File: rtl/sdcc_checker.sv
module sdcc_checker
    import sdcc_pkg::*;
#(
    parameter int NBANK     = 4,
    parameter int TRCD      = 3,
    parameter int TRAS      = 6,
    parameter int TRP       = 3,
    parameter int TRRD      = 2,
    parameter int TRC       = 8,
    parameter int TMRD      = 2,
    parameter int TDPL      = 2,
    parameter int BURST_LEN = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n,
    input  logic                     ras_n,
    input  logic                     cas_n,
    input  logic                     we_n,
    input  logic [$clog2(NBANK)-1:0] ba,
    input  logic                     ap,
    output logic                     err_pulse,
    output logic [3:0]               err_code,
    output logic [$clog2(NBANK)-1:0] err_bank
);

    localparam int BAW = $clog2(NBANK);

    typedef struct packed {
        logic           pulse;
        err_e           code;
        logic [BAW-1:0] bank;
    } rep_t;

    cmd_e             cmd_w;
    err_e             bank_err [NBANK];
    logic [NBANK-1:0] bank_idle;
    logic [NBANK-1:0] bank_sel;
    logic             dev_busy;
    logic             rrd_short;
    logic             accept;
    err_e             code_c;
    logic [BAW-1:0]   bank_c;
    rep_t             r_q, r_d;

    sdcc_decode u_decode (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd_w)
    );

    generate
        for (genvar i = 0; i < NBANK; i++) begin : g_bank
            assign bank_sel[i] = (cmd_w == C_PRE && ap) || (ba == BAW'(i));
            sdcc_bank #(
                .TRCD      (TRCD),
                .TRAS      (TRAS),
                .TRP       (TRP),
                .TDPL      (TDPL),
                .BURST_LEN (BURST_LEN)
            ) u_bank (
                .clk    (clk),
                .rst_n  (rst_n),
                .cmd    (cmd_w),
                .sel    (bank_sel[i]),
                .ap     (ap),
                .accept (accept),
                .err    (bank_err[i]),
                .idle   (bank_idle[i])
            );
        end
    endgenerate

    sdcc_device #(
        .TRC  (TRC),
        .TMRD (TMRD),
        .TRRD (TRRD)
    ) u_device (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd_w),
        .accept    (accept),
        .busy      (dev_busy),
        .rrd_short (rrd_short)
    );

    // Arbitration: device rules, then lowest offending bank, then spacing
    always_comb begin
        logic           found;
        err_e           fcode;
        logic [BAW-1:0] fidx;
        found = 1'b0;
        fcode = E_NONE;
        fidx  = '0;
        for (int i = NBANK - 1; i >= 0; i--) begin
            if (bank_err[i] != E_NONE) begin
                found = 1'b1;
                fcode = bank_err[i];
                fidx  = BAW'(i);
            end
        end
        code_c = E_NONE;
        bank_c = ba;
        if (dev_busy && cmd_w != C_NOP && cmd_w != C_DESEL) begin
            code_c = E_DEV_BUSY;
        end else if ((cmd_w == C_MRS || cmd_w == C_REF) && !(&bank_idle)) begin
            code_c = E_DEV_OPEN;
        end else if (found) begin
            code_c = fcode;
            bank_c = fidx;
        end else if (cmd_w == C_ACT && rrd_short) begin
            code_c = E_TRRD;
        end
        if (code_c == E_NONE) bank_c = '0;
    end

    assign accept = (code_c == E_NONE);

    always_comb begin
        r_d.pulse = !accept;
        r_d.code  = code_c;
        r_d.bank  = bank_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.pulse <= 1'b0;
            r_q.code  <= E_NONE;
            r_q.bank  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign err_pulse = r_q.pulse;
    assign err_code  = r_q.code;
    assign err_bank  = r_q.bank;

    // R2: no-op and deselect never raise an error
    a_r2_quiet_cmds: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(cmd_w != C_NOP && cmd_w != C_DESEL));

    // R6: a real command in a busy window is reported as a device error
    a_r6_busy_report: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_busy && cmd_w != C_NOP && cmd_w != C_DESEL)
            |=> (err_pulse && err_code == 4'(E_DEV_BUSY)));

endmodule

// File: tb/sdcc_checker_test.sv
module sdcc_checker_test;

    localparam int CLK_PERIOD = 10;

    localparam logic [3:0] OP_MRS = 4'd0, OP_REF = 4'd1, OP_PRE = 4'd2, OP_ACT = 4'd3,
                           OP_WR  = 4'd4, OP_RD  = 4'd5, OP_NOP = 4'd7, OP_DES = 4'd8;

    logic       clk   = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n  = 1'b1;
    logic       ras_n = 1'b1;
    logic       cas_n = 1'b1;
    logic       we_n  = 1'b1;
    logic [1:0] ba    = 2'd0;
    logic       ap    = 1'b0;
    logic       err_pulse;
    logic [3:0] err_code;
    logic [1:0] err_bank;

    logic [3:0] q_code [$];
    logic [1:0] q_bank [$];
    string      q_tag  [$];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    sdcc_checker uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .ba        (ba),
        .ap        (ap),
        .err_pulse (err_pulse),
        .err_code  (err_code),
        .err_bank  (err_bank)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Driver: one command per cycle, expectation pushed to the scoreboard
    task automatic issue(input logic [3:0] op, input logic [1:0] b, input logic a,
                         input logic [3:0] code, input logic [1:0] eb, input string tag);
        @(negedge clk);
        if (op == OP_DES) begin
            cs_n = 1'b1;
            {ras_n, cas_n, we_n} = 3'b111;
        end else begin
            cs_n = 1'b0;
            {ras_n, cas_n, we_n} = op[2:0];
        end
        ba = b;
        ap = a;
        q_code.push_back(code);
        q_bank.push_back((code == 4'd0) ? 2'd0 : eb);
        q_tag.push_back(tag);
    endtask

    task automatic idle_n(input int n, input string tag);
        for (int i = 0; i < n; i++) issue(OP_NOP, 2'd0, 1'b0, 4'd0, 2'd0, tag);
    endtask

    // Monitor: compare each registered result one quarter period after the edge
    initial begin
        logic [3:0] c;
        logic [1:0] b;
        string      t;
        forever begin
            @(posedge clk);
            #(CLK_PERIOD / 4);
            if (q_code.size() > 0) begin
                c = q_code.pop_front();
                b = q_bank.pop_front();
                t = q_tag.pop_front();
                checks++;
                if (err_pulse !== (c != 4'd0) || err_code !== c || err_bank !== b) begin
                    fails++;
                    $display("FAIL %s: got pulse=%0b code=%0d bank=%0d, expected pulse=%0b code=%0d bank=%0d",
                             t, err_pulse, err_code, err_bank, (c != 4'd0), c, b);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 2000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (err_pulse !== 1'b0 || err_code !== 4'd0 || err_bank !== 2'd0) begin
            fails++;
            $display("FAIL R1 reset: got pulse=%0b code=%0d bank=%0d, expected 0 0 0",
                     err_pulse, err_code, err_bank);
        end
        rst_n = 1'b1;

        issue(OP_RD,  2'd0, 1'b0, 4'd3, 2'd0, "R3 read of idle bank");
        issue(OP_WR,  2'd1, 1'b0, 4'd3, 2'd1, "R3 write of idle bank");
        issue(OP_ACT, 2'd0, 1'b0, 4'd0, 2'd0, "R12 open bank 0");
        issue(OP_RD,  2'd0, 1'b0, 4'd6, 2'd0, "R8 read one cycle after activate");
        idle_n(1, "R8 wait");
        issue(OP_RD,  2'd0, 1'b0, 4'd0, 2'd0, "R8 read exactly at TRCD");
        issue(OP_PRE, 2'd0, 1'b0, 4'd7, 2'd0, "R9 precharge before TRAS");
        issue(OP_RD,  2'd0, 1'b0, 4'd0, 2'd0, "R13 rejected precharge kept row, R12 read restarts read");
        issue(OP_WR,  2'd0, 1'b0, 4'd0, 2'd0, "R12 write interrupts read");
        idle_n(3, "R12 write burst");
        issue(OP_PRE, 2'd0, 1'b0, 4'd9, 2'd0, "R11 precharge in write recovery");
        idle_n(1, "R11 recovery");
        issue(OP_PRE, 2'd0, 1'b0, 4'd0, 2'd0, "R11 precharge after recovery");
        issue(OP_ACT, 2'd0, 1'b0, 4'd10, 2'd0, "R4 activate during TRP");
        idle_n(1, "R4 wait");
        issue(OP_ACT, 2'd0, 1'b0, 4'd0, 2'd0, "R4 activate after TRP");
        issue(OP_ACT, 2'd1, 1'b0, 4'd8, 2'd1, "R10 activate before TRRD");
        issue(OP_ACT, 2'd1, 1'b0, 4'd0, 2'd0, "R10 activate at TRRD");
        issue(OP_ACT, 2'd0, 1'b0, 4'd4, 2'd0, "R4 R14 activate of opening bank");
        issue(OP_REF, 2'd2, 1'b0, 4'd2, 2'd2, "R7 refresh with rows open");
        issue(OP_MRS, 2'd0, 1'b0, 4'd2, 2'd0, "R7 mode load with rows open");
        issue(OP_PRE, 2'd0, 1'b1, 4'd7, 2'd1, "R2 precharge-all names lowest offending bank");
        idle_n(1, "R9 wait");
        issue(OP_PRE, 2'd0, 1'b1, 4'd0, 2'd0, "R9 precharge-all after TRAS");
        issue(OP_REF, 2'd0, 1'b0, 4'd2, 2'd0, "R7 refresh while precharging");
        idle_n(1, "R7 wait");
        issue(OP_REF, 2'd0, 1'b0, 4'd0, 2'd0, "R6 refresh with all idle");
        issue(OP_ACT, 2'd2, 1'b0, 4'd1, 2'd2, "R6 activate during refresh");
        issue(OP_RD,  2'd3, 1'b0, 4'd1, 2'd3, "R14 busy outranks bank error");
        issue(OP_DES, 2'd1, 1'b0, 4'd0, 2'd0, "R6 deselect during refresh");
        idle_n(4, "R6 no-op during refresh");
        issue(OP_MRS, 2'd0, 1'b0, 4'd0, 2'd0, "R6 mode load after TRC");
        issue(OP_ACT, 2'd3, 1'b0, 4'd1, 2'd3, "R6 activate inside mode-load window");
        issue(OP_ACT, 2'd3, 1'b0, 4'd0, 2'd0, "R6 activate after mode-load window");
        idle_n(2, "R12 wait");
        issue(OP_RD,  2'd3, 1'b1, 4'd0, 2'd0, "R12 read with auto precharge");
        issue(OP_WR,  2'd3, 1'b0, 4'd5, 2'd3, "R5 write during auto-precharge read");
        issue(OP_PRE, 2'd3, 1'b0, 4'd5, 2'd3, "R5 precharge during auto-precharge read");
        idle_n(1, "R12 burst");
        issue(OP_ACT, 2'd3, 1'b0, 4'd10, 2'd3, "R4 activate while auto precharge runs");
        idle_n(2, "R12 auto precharge");
        issue(OP_ACT, 2'd3, 1'b0, 4'd0, 2'd0, "R12 bank idle after auto precharge");
        idle_n(2, "R12 wait");
        issue(OP_WR,  2'd3, 1'b1, 4'd0, 2'd0, "R12 write with auto precharge");
        idle_n(4, "R12 write burst");
        issue(OP_RD,  2'd3, 1'b0, 4'd5, 2'd3, "R5 read in auto-precharge write recovery");
        idle_n(2, "R12 recovery");
        issue(OP_ACT, 2'd3, 1'b0, 4'd10, 2'd3, "R4 activate before auto precharge ends");
        issue(OP_ACT, 2'd3, 1'b0, 4'd0, 2'd0, "R12 activate after auto precharge");
        idle_n(3, "R1 quiet bus");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule